// File: doc/BRIEF.md
# Codec Register Bank Controller

This block holds the sixteen-bit control registers of an audio codec that sit behind a link controller's command and status slots. Each request carries a seven-bit register address, a read or write flag and sixteen bits of write data. A write is filtered and reshaped by rules that depend on its address. A read is answered one clock later with a response that carries the address echo, two slot-valid tags and a data word. Some fields of that word come from live signals rather than from storage.

Three control bits are held in shadow flip-flops: the link-disable bit, the sample-rate flag and the readback-mode bit. A hardware reset clears them, and so does any write to address 00h. A warm-reset event clears only the link-disable bit. The readback-mode bit chooses between raw readback of the stored word and readback with reserved bits forced to zero. The codec-identifier strap pin is sampled live on every read of the two identification registers.

Top module: `ac97_regbank`

## Requirements
- R1: After hardware reset, 7Ch reads 4152h, 7Eh reads 0130h, 28h reads 0205h with the strap low, every other even register reads 0000h, link_off is 0, and readback is raw.
- R2: A read request gives exactly one response with rsp_valid high, rsp_tags equal to 2'b11 and rsp_addr echoing the address, on the clock edge after the request. A write request gives no response.
- R3: Writes to 7Ch, 7Eh and 28h leave the stored value unchanged.
- R4: A write to 26h stores data bits 15:4 with bits 3:0 forced to 1110b. Data bit 12 of that write becomes the new link_off value.
- R5: A write to 2Ah stores the data with bits 9:6 forced to 0111b.
- R6: A write to 32h or 34h stores BB80h whatever data is supplied.
- R7: Any write to 2Ch, 2Eh or 30h sets the rate flag to 1 if the data equals AC44h and to 0 otherwise. A read of any of these three registers returns AC44h when the flag is 1 and BB80h when it is 0.
- R8: On reads of 28h and 3Ch, bit 14 equals codec_sel at the time of the request and bit 15 is 0. The other bits come from storage.
- R9: Bit 12 of a 26h read shows the live link_off value. A warm_reset pulse clears link_off one edge later, and it takes priority over a write to 26h in the same cycle.
- R10: A read of an odd address returns data 0000h, tags 2'b11 and the odd address. A write to an odd address changes nothing.
- R11: Bit 0 of a write to 5Ah sets the readback mode. When it is 1, read data is ANDed with a per-address mask: 00h FFFFh; 02h–1Eh 9F3Fh; 26h FF0Fh; 28h C3FFh; 2Ah 07FFh; 2Ch–34h FFFFh; 3Ch FFFFh; 5Ah 0001h; 7Ch and 7Eh FFFFh; every other address 0000h. When it is 0, the full word is returned.
- R12: A write to 00h stores its data and clears link_off, the rate flag and the readback mode. Stored registers are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Write data |
| codec_sel | input | 1 | Codec-identifier strap pin |
| warm_reset | input | 1 | Warm-reset event, one-cycle pulse |
| rsp_valid | output | 1 | Read response present |
| rsp_addr | output | 7 | Address of the answered read |
| rsp_data | output | 16 | Read data |
| rsp_tags | output | 2 | Slot-valid tags {address slot, data slot} |
| link_off | output | 1 | Link-disable control bit |

## Verification
The hardest state to reach from the ports is a mix of shadow bits that disagrees with storage. One case is link_off cleared by a warm reset while 26h still holds a 1 in bit 12. Another is the readback mode cleared by a write to 00h while 5Ah still stores a 1. The stimulus builds both on purpose: it writes 26h, 2Ch and 5Ah, then issues a warm reset or a 00h write, then reads back each affected register. It finishes with a long random sweep that interleaves strap changes and warm pulses with reads and writes of the special addresses.

// File: rtl/ac97_rb_pkg.sv
// Shared constants and per-address rules for the codec register bank.
// Assumes 7-bit byte addresses with the register index in bits 6:1.
package ac97_rb_pkg;

    localparam int REG_W = 16;

    localparam logic [6:0] A_SWRST  = 7'h00;
    localparam logic [6:0] A_PWRCTL = 7'h26;
    localparam logic [6:0] A_EXTID  = 7'h28;
    localparam logic [6:0] A_EXTCTL = 7'h2A;
    localparam logic [6:0] A_RATE0  = 7'h2C;
    localparam logic [6:0] A_RATE1  = 7'h2E;
    localparam logic [6:0] A_RATE2  = 7'h30;
    localparam logic [6:0] A_ADCR0  = 7'h32;
    localparam logic [6:0] A_ADCR1  = 7'h34;
    localparam logic [6:0] A_MDMID  = 7'h3C;
    localparam logic [6:0] A_RDMODE = 7'h5A;
    localparam logic [6:0] A_VID1   = 7'h7C;
    localparam logic [6:0] A_VID2   = 7'h7E;

    localparam logic [REG_W-1:0] RATE_48K = 16'hBB80;
    localparam logic [REG_W-1:0] RATE_44K = 16'hAC44;

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] val;
    } wr_shape_t;

    // True for the three sample-rate registers that share one flag
    function automatic logic is_rate_reg(logic [6:0] a);
        return (a == A_RATE0) || (a == A_RATE1) || (a == A_RATE2);
    endfunction

    // Decide whether a write lands in storage and which value it stores
    function automatic wr_shape_t shape_write(logic [6:0] a, logic [REG_W-1:0] d);
        wr_shape_t s;
        s.en  = 1'b1;
        s.val = d;
        if (a[0] || a == A_VID1 || a == A_VID2 || a == A_EXTID) begin
            s.en = 1'b0;
        end else if (a == A_PWRCTL) begin
            s.val = {d[15:4], 4'b1110};
        end else if (a == A_EXTCTL) begin
            s.val = {d[15:10], 4'b0111, d[5:0]};
        end else if (a == A_ADCR0 || a == A_ADCR1) begin
            s.val = RATE_48K;
        end
        return s;
    endfunction

    // Bits that survive readback in compliant mode
    function automatic logic [REG_W-1:0] keep_mask(logic [6:0] a);
        logic [REG_W-1:0] m;
        m = 16'h0000;
        if (a == A_SWRST)                     m = 16'hFFFF;
        else if (a >= 7'h02 && a <= 7'h1E)    m = 16'h9F3F;
        else if (a == A_PWRCTL)               m = 16'hFF0F;
        else if (a == A_EXTID)                m = 16'hC3FF;
        else if (a == A_EXTCTL)               m = 16'h07FF;
        else if (a >= A_RATE0 && a <= A_ADCR1) m = 16'hFFFF;
        else if (a == A_MDMID)                m = 16'hFFFF;
        else if (a == A_RDMODE)               m = 16'h0001;
        else if (a == A_VID1 || a == A_VID2)  m = 16'hFFFF;
        return m;
    endfunction

endpackage

// File: rtl/ac97_rb_store.sv
// Register storage: one REG_W word per even address.
// Assumes the caller has already applied the write-filtering rules.
module ac97_rb_store
    import ac97_rb_pkg::*;
#(
    parameter int               ADDR_W    = 7,
    parameter logic [REG_W-1:0] VID1      = 16'h4152,
    parameter logic [REG_W-1:0] VID2      = 16'h0130,
    parameter logic [REG_W-1:0] EXTID_DEF = 16'h0205
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-2:0]   wr_idx,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [ADDR_W-2:0]   rd_idx,
    output logic [REG_W-1:0]    rd_word
);
    localparam int NREG = 2 ** (ADDR_W - 1);

    logic [REG_W-1:0] regs [NREG];
    logic [REG_W-1:0] init_val [NREG];

    // Reset value for each register, chosen per index at elaboration
    for (genvar i = 0; i < NREG; i++) begin : g_init
        localparam logic [6:0] A = 7'(2 * i);
        if (A == A_VID1)       begin : g_v1 assign init_val[i] = VID1;      end
        else if (A == A_VID2)  begin : g_v2 assign init_val[i] = VID2;      end
        else if (A == A_EXTID) begin : g_ei assign init_val[i] = EXTID_DEF; end
        else                   begin : g_z  assign init_val[i] = '0;        end
    end

    // Load reset values, otherwise accept filtered writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= init_val[i];
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_word = regs[rd_idx];
endmodule

// File: rtl/ac97_rb_shadow.sv
// Shadow control flip-flops: link disable, rate flag, readback mode.
// Assumes wr_en marks a write to an even address; a 00h write clears all.
module ac97_rb_shadow
    import ac97_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [6:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             warm_reset,
    output logic             link_off,
    output logic             rate_44k,
    output logic             compliant
);
    // Update shadow bits; software reset and warm reset take precedence
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_en && wr_addr == A_SWRST)) begin
            link_off  <= 1'b0;
            rate_44k  <= 1'b0;
            compliant <= 1'b0;
        end else begin
            if (warm_reset)                          link_off  <= 1'b0;
            else if (wr_en && wr_addr == A_PWRCTL)   link_off  <= wr_data[12];
            if (wr_en && is_rate_reg(wr_addr))       rate_44k  <= (wr_data == RATE_44K);
            if (wr_en && wr_addr == A_RDMODE)        compliant <= wr_data[0];
        end
    end
endmodule

// File: rtl/ac97_rb_readpath.sv
// Read response builder: substitutes live fields, masks, and registers.
// Assumes stored is the word at the even index of rd_addr.
module ac97_rb_readpath
    import ac97_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [6:0]       rd_addr,
    input  logic [REG_W-1:0] stored,
    input  logic             codec_sel,
    input  logic             link_off,
    input  logic             rate_44k,
    input  logic             compliant,
    output logic             rsp_valid,
    output logic [6:0]       rsp_addr,
    output logic [REG_W-1:0] rsp_data,
    output logic [1:0]       rsp_tags
);
    logic [REG_W-1:0] word;

    // Form the outgoing word from storage and live state
    always_comb begin
        word = stored;
        if (is_rate_reg(rd_addr)) word = rate_44k ? RATE_44K : RATE_48K;
        if (rd_addr == A_EXTID || rd_addr == A_MDMID) begin
            word[14] = codec_sel;
            word[15] = 1'b0;
        end
        if (rd_addr == A_PWRCTL) word[12] = link_off;
        if (compliant) word = word & keep_mask(rd_addr);
        if (rd_addr[0]) word = '0;
    end

    // Register the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_data  <= '0;
            rsp_tags  <= 2'b00;
        end else begin
            rsp_valid <= rd_en;
            rsp_addr  <= rd_en ? rd_addr : '0;
            rsp_data  <= rd_en ? word : '0;
            rsp_tags  <= rd_en ? 2'b11 : 2'b00;
        end
    end
endmodule

// File: rtl/ac97_regbank.sv
// Codec register bank controller top: decodes requests and ties storage,
// shadow bits and the read path together. Assumes one request per cycle.
module ac97_regbank
    import ac97_rb_pkg::*;
#(
    parameter int               ADDR_W    = 7,
    parameter logic [REG_W-1:0] VID1      = 16'h4152,
    parameter logic [REG_W-1:0] VID2      = 16'h0130,
    parameter logic [REG_W-1:0] EXTID_DEF = 16'h0205
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic              codec_sel,
    input  logic              warm_reset,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [REG_W-1:0]  rsp_data,
    output logic [1:0]        rsp_tags,
    output logic              link_off
);
    wr_shape_t        shp;
    logic             wr_even;
    logic             rd_en;
    logic [REG_W-1:0] stored;
    logic             rate_44k;
    logic             compliant;

    // Request decode and write shaping
    always_comb begin
        wr_even = req_valid && req_write && !req_addr[0];
        rd_en   = req_valid && !req_write;
        shp     = shape_write(req_addr, req_wdata);
    end

    ac97_rb_store #(
        .ADDR_W(ADDR_W), .VID1(VID1), .VID2(VID2), .EXTID_DEF(EXTID_DEF)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_even && shp.en),
        .wr_idx  (req_addr[ADDR_W-1:1]),
        .wr_data (shp.val),
        .rd_idx  (req_addr[ADDR_W-1:1]),
        .rd_word (stored)
    );

    ac97_rb_shadow i_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_even),
        .wr_addr    (req_addr),
        .wr_data    (req_wdata),
        .warm_reset (warm_reset),
        .link_off   (link_off),
        .rate_44k   (rate_44k),
        .compliant  (compliant)
    );

    ac97_rb_readpath i_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (req_addr),
        .stored    (stored),
        .codec_sel (codec_sel),
        .link_off  (link_off),
        .rate_44k  (rate_44k),
        .compliant (compliant),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_data  (rsp_data),
        .rsp_tags  (rsp_tags)
    );
endmodule

// File: rtl/ac97_rb_checker.sv
// Protocol and rule checks for the register bank, bound to its top.
// Assumes the default 7-bit address and 16-bit data widths.
module ac97_rb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [6:0]  req_addr,
    input logic        warm_reset,
    input logic        rsp_valid,
    input logic [6:0]  rsp_addr,
    input logic [15:0] rsp_data,
    input logic [1:0]  rsp_tags,
    input logic        link_off
);
    AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R2
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rsp_valid && rsp_tags == 2'b11 && rsp_addr == $past(req_addr))); // R2
    AST_ODD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_addr[0]) |-> (rsp_data == 16'h0000)); // R10
    AST_ID_TOP_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_addr == 7'h28 || rsp_addr == 7'h3C)) |-> !rsp_data[15]); // R8
    AST_WARM_CLEARS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        warm_reset |=> !link_off); // R9
    AST_RATE_TWO_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_addr == 7'h2C || rsp_addr == 7'h2E || rsp_addr == 7'h30))
        |-> (rsp_data == 16'hBB80 || rsp_data == 16'hAC44)); // R7
endmodule

bind ac97_regbank ac97_rb_checker i_rb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .warm_reset (warm_reset),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_data   (rsp_data),
    .rsp_tags   (rsp_tags),
    .link_off   (link_off)
);

// File: tb/test_ac97_regbank.sv
module test_ac97_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        codec_sel = 1'b0;
    logic        warm_reset = 1'b0;
    logic        rsp_valid;
    logic [6:0]  rsp_addr;
    logic [15:0] rsp_data;
    logic [1:0]  rsp_tags;
    logic        link_off;

    always #4 clk = ~clk;

    ac97_regbank i_ac97_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .codec_sel(codec_sel),
        .warm_reset(warm_reset), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .rsp_tags(rsp_tags), .link_off(link_off)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Behavioural reference state
    int m_mem [128];
    bit m_link, m_rate, m_mode;
    bit e_v;
    int e_a, e_d;
    string e_tag;

    function automatic int mask_of(int a);
        if (a == 0) return 'hFFFF;
        if (a >= 2 && a <= 'h1E) return 'h9F3F;
        case (a)
            'h26: return 'hFF0F;
            'h28: return 'hC3FF;
            'h2A: return 'h07FF;
            'h2C, 'h2E, 'h30, 'h32, 'h34, 'h3C, 'h7C, 'h7E: return 'hFFFF;
            'h5A: return 'h0001;
            default: return 0;
        endcase
    endfunction

    function automatic void model_reset();
        foreach (m_mem[i]) m_mem[i] = 0;
        m_mem['h7C] = 'h4152;
        m_mem['h7E] = 'h0130;
        m_mem['h28] = 'h0205;
        m_link = 0; m_rate = 0; m_mode = 0;
    endfunction

    function automatic int model_read(int a, bit strap);
        int v;
        if (a % 2 == 1) return 0;
        v = m_mem[a];
        if (a == 'h2C || a == 'h2E || a == 'h30) v = m_rate ? 'hAC44 : 'hBB80;
        if (a == 'h28 || a == 'h3C) begin
            v = v & 'h3FFF;
            if (strap) v = v | 'h4000;
        end
        if (a == 'h26) v = (v & 'hEFFF) | (m_link ? 'h1000 : 0);
        if (m_mode) v = v & mask_of(a);
        return v;
    endfunction

    function automatic void model_write(int a, int d, bit warm);
        if (a % 2 == 1) begin
            if (warm) m_link = 0;
            return;
        end
        if (a == 0) begin
            m_mem[0] = d; m_link = 0; m_rate = 0; m_mode = 0;
            return;
        end
        case (a)
            'h7C, 'h7E, 'h28: ;
            'h26: m_mem[a] = (d & 'hFFF0) | 'hE;
            'h2A: m_mem[a] = (d & ~'h03C0) | 'h01C0;
            'h32, 'h34: m_mem[a] = 'hBB80;
            default: m_mem[a] = d;
        endcase
        if (a == 'h2C || a == 'h2E || a == 'h30) m_rate = (d == 'hAC44);
        if (a == 'h5A) m_mode = d[0];
        if (warm) m_link = 0;
        else if (a == 'h26) m_link = d[12];
    endfunction

    task automatic check_outputs();
        n_chk++;
        if (e_v) begin
            if (!(rsp_valid === 1'b1 && rsp_tags === 2'b11 && int'(rsp_addr) == e_a && int'(rsp_data) == e_d)) begin
                n_fail++;
                $display("FAIL %s: rsp v=%b tags=%b addr=%h data=%h, expected v=1 tags=11 addr=%h data=%h",
                         e_tag, rsp_valid, rsp_tags, rsp_addr, rsp_data, e_a[6:0], e_d[15:0]);
            end
        end else if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: rsp_valid=%b after non-read, expected 0", rsp_valid);
        end
        n_chk++;
        if (link_off !== m_link) begin
            n_fail++;
            $display("FAIL R9/R4/R12: link_off=%b expected %b", link_off, m_link);
        end
    endtask

    // One request per cycle: check the previous cycle's result, then drive
    task automatic op(bit v, bit w, int a, int d, bit strap, bit warm, string tag);
        @(negedge clk);
        check_outputs();
        req_valid = v; req_write = w; req_addr = 7'(a); req_wdata = 16'(d);
        codec_sel = strap; warm_reset = warm;
        e_v = v && !w; e_a = a; e_tag = tag;
        e_d = e_v ? model_read(a, strap) : 0;
        if (v && w) model_write(a, d, warm);
        else if (warm) m_link = 0;
    endtask

    task automatic wr(int a, int d, string tag); op(1, 1, a, d, 0, 0, tag); endtask
    task automatic rd(int a, string tag);        op(1, 0, a, 0, 0, 0, tag); endtask

    initial begin
        int addrs [16] = '{'h00, 'h02, 'h26, 'h28, 'h2A, 'h2C, 'h2E, 'h30,
                           'h32, 'h3C, 'h5A, 'h7C, 'h40, 'h2D, 'h03, 'h1E};
        model_reset();
        e_v = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd('h7C, "R1"); rd('h7E, "R1"); rd('h28, "R1"); rd('h02, "R1"); rd('h26, "R1");
        // R3 ignored writes
        wr('h7C, 'hFFFF, "R3"); rd('h7C, "R3");
        wr('h7E, 'h0000, "R3"); rd('h7E, "R3");
        wr('h28, 'hFFFF, "R3"); rd('h28, "R3");
        // R4 and R9 power control
        wr('h26, 'h1235, "R4"); rd('h26, "R4");
        op(0, 0, 0, 0, 0, 1, "R9"); rd('h26, "R9");
        op(1, 1, 'h26, 'h1000, 0, 1, "R9"); rd('h26, "R9");
        // R5 forced field
        wr('h2A, 'hFFFF, "R5"); rd('h2A, "R5");
        wr('h2A, 'h0000, "R5"); rd('h2A, "R5");
        // R6 fixed ADC rate
        wr('h32, 'h1234, "R6"); rd('h32, "R6");
        wr('h34, 'h0000, "R6"); rd('h34, "R6");
        // R7 shared rate flag
        rd('h2C, "R7");
        wr('h2E, 'hAC44, "R7"); rd('h2C, "R7"); rd('h2E, "R7"); rd('h30, "R7");
        wr('h30, 'h1111, "R7"); rd('h2E, "R7");
        // R8 strap and top bit
        op(1, 0, 'h28, 0, 1, 0, "R8");
        wr('h3C, 'hFFFF, "R8");
        op(1, 0, 'h3C, 0, 1, 0, "R8"); op(1, 0, 'h3C, 0, 0, 0, "R8");
        // R10 odd addresses
        rd('h2D, "R10"); rd('h7F, "R10");
        wr('h03, 'hFFFF, "R10"); rd('h02, "R10"); rd('h03, "R10");
        // R11 readback mode
        wr('h02, 'hFFFF, "R11"); rd('h02, "R11");
        wr('h40, 'hFFFF, "R11");
        wr('h5A, 'h0001, "R11");
        rd('h02, "R11"); rd('h26, "R11"); rd('h40, "R11"); rd('h5A, "R11"); rd('h2A, "R11");
        wr('h5A, 'h0000, "R11"); rd('h40, "R11");
        // R12 software reset
        wr('h2C, 'hAC44, "R12"); wr('h26, 'h1000, "R12"); wr('h5A, 'h0001, "R12");
        wr('h00, 'hABCD, "R12");
        rd('h00, "R12"); rd('h2C, "R12"); rd('h40, "R12"); rd('h26, "R12");
        // Mixed random sweep over all rules
        for (int k = 0; k < 400; k++) begin
            int a;
            a = addrs[$urandom_range(15)];
            op(1, $urandom_range(1), a, (($urandom_range(3) == 0) ? 'hAC44 : int'($urandom_range(65535))),
               $urandom_range(1), ($urandom_range(7) == 0), "R2");
        end
        op(0, 0, 0, 0, 0, 0, "R2");
        @(negedge clk);
        check_outputs();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule